// File: doc/BRIEF.md
# Bus-Master DMA Channel Registers

This block holds the software-visible control state of a two-channel bus-master DMA engine for a storage bus. A host reaches it through a byte-addressed register port. Each channel has a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. The block keeps these registers consistent while a transfer is running. It also turns software start and stop requests into single-cycle pulses that drive the descriptor fetch engine.

Each channel uses an 8-byte window, and address bit 3 selects the channel. Inside a window, byte 0 is the command byte, byte 2 is the status byte and bytes 4 to 7 are the descriptor pointer in little-endian order. Bytes 1 and 3 read as zero.

In the command byte, bit 0 is the run bit and bit 3 is the transfer direction bit. In the status byte:

- bit 0 is the active flag;
- bit 1 is the error flag;
- bit 2 is the interrupt flag;
- bits 5 and 6 are plain read/write storage.

Access size is coded as 0 for one byte, 1 for two bytes, 2 for four bytes, and 3 is never legal.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset every register bit reads zero, and `rvalid`, `acc_err`, `dma_start`, `dma_abort` and `dma_ptr` are zero.
- R2: While the run bit (command bit 0) is 1, a command write cannot change the direction bit (command bit 3); while the run bit is 0, a command write sets that bit freely.
- R3: A command write that changes the run bit from 0 to 1 sets status bit 0 and raises that channel's `dma_start` bit for one cycle, one cycle after the write. In the same cycle that channel's slice of `dma_ptr` shows the descriptor pointer held before the write, and it keeps that value until the next start.
- R4: A command write that changes the run bit from 1 to 0 clears status bit 0 and raises that channel's `dma_abort` bit for one cycle, one cycle after the write. A command write that leaves the run bit unchanged raises neither pulse.
- R5: Status bit 0 cannot be changed by a status write.
- R6: Writing 1 to status bit 1 or bit 2 clears it; writing 0 leaves it unchanged. Status bits 5 and 6 take the written value.
- R7: `hw_err[c]` and `hw_irq[c]` set status bit 1 and bit 2 of channel c. A hardware set in the same cycle as a software clear leaves the bit set.
- R8: A four-byte write at offset 4 loads the descriptor pointer with its two low bits forced to zero.
- R9: A read of 1, 2 or 4 bytes at an address aligned to its size returns, one cycle later with `rvalid` high, the addressed bytes little-endian in the low bits of `rdata`, with the upper bits zero.
- R10: With `io_en` low, a request changes nothing and raises no error; a read still completes with `rvalid` high and `rdata` zero.
- R11: With `bm_en` low, writes change nothing and raise no error, while reads work as usual.
- R12: A write is legal only as a single byte at offset 0 or 2, or four bytes at offset 4. A read is legal only with size 0 to 2 and aligned to its size. An illegal access (with I/O enabled, and for writes with bus mastering enabled) pulses `acc_err` one cycle later and changes no register; an illegal read returns `rdata` zero.
- R13: The two channels are independent: an access to one channel never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master enable, gates writes |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte address; bit 3 selects the channel |
| size | input | 2 | Access size code |
| wdata | input | 32 | Write data, little-endian |
| hw_irq | input | 2 | Per-channel interrupt event |
| hw_err | input | 2 | Per-channel error event |
| rvalid | output | 1 | Read completion, one cycle after a read request |
| rdata | output | 32 | Read data |
| acc_err | output | 1 | Illegal access pulse |
| dma_start | output | 2 | Per-channel start pulse |
| dma_abort | output | 2 | Per-channel abort pulse |
| dma_ptr | output | 64 | Per-channel pointer captured at start (channel c at bits 32c+31:32c) |

## Verification
The hardest case to reach is a write-one-to-clear that lands in the same cycle as a hardware event on the same flag. It matters most when a transfer is running at that moment, because the direction lock and the active flag must also hold. A directed sequence starts a channel, sets both flags by hardware, and then issues clears that coincide with new events. A seeded random phase then drives hardware events on about one cycle in ten, alongside random writes and reads. These cover the coincidences again in both channels and with the enables toggled. A bench model predicts every register and pulse in every cycle.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_RW_LO = 5;
  localparam int ST_RW_HI = 6;
  localparam int OFF_CMD = 0;
  localparam int OFF_STS = 2;
  localparam int OFF_PTR = 4;
  localparam int WIN_BYTES = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_sz_e;
endpackage

// File: rtl/bm_chan.sv
module bm_chan
  import bm_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          wr_sts,
  input  logic          wr_ptr,
  input  logic [PW-1:0] wdata,
  input  logic          hw_irq,
  input  logic          hw_err,
  output logic [7:0]    cmd_q,
  output logic [7:0]    sts_q,
  output logic [PW-1:0] ptr_q,
  output logic          start_o,
  output logic          abort_o,
  output logic [PW-1:0] start_ptr_o
);
  logic run_w, go, halt;

  always_comb begin
    run_w = wdata[CMD_RUN];
    go    = wr_cmd && !cmd_q[CMD_RUN] && run_w;
    halt  = wr_cmd && cmd_q[CMD_RUN] && !run_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= '0;
      sts_q       <= '0;
      ptr_q       <= '0;
      start_o     <= 1'b0;
      abort_o     <= 1'b0;
      start_ptr_o <= '0;
    end else begin
      start_o <= go;
      abort_o <= halt;
      if (go) start_ptr_o <= ptr_q;
      if (wr_cmd) begin
        cmd_q[CMD_RUN] <= run_w;
        if (!cmd_q[CMD_RUN]) cmd_q[CMD_DIR] <= wdata[CMD_DIR];
      end
      if (go)        sts_q[ST_ACT] <= 1'b1;
      else if (halt) sts_q[ST_ACT] <= 1'b0;
      if (hw_err)                        sts_q[ST_ERR] <= 1'b1;
      else if (wr_sts && wdata[ST_ERR])  sts_q[ST_ERR] <= 1'b0;
      if (hw_irq)                        sts_q[ST_IRQ] <= 1'b1;
      else if (wr_sts && wdata[ST_IRQ])  sts_q[ST_IRQ] <= 1'b0;
      if (wr_sts) sts_q[ST_RW_HI:ST_RW_LO] <= wdata[ST_RW_HI:ST_RW_LO];
      if (wr_ptr) ptr_q <= {wdata[PW-1:2], 2'b00};
    end
  end

  // R2: direction frozen while running
  a_r2_dir_locked: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[CMD_RUN] && wr_cmd) |=> (cmd_q[CMD_DIR] == $past(cmd_q[CMD_DIR])));
  // R3: start pulse comes with active set
  a_r3_start_active: assert property (@(posedge clk) disable iff (rst)
    start_o |-> sts_q[ST_ACT]);
  // R4: abort pulse comes with active cleared
  a_r4_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !sts_q[ST_ACT]);
  // R4: never both pulses
  a_r4_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, abort_o}));
  // R7: hardware set wins
  a_r7_hw_err_wins: assert property (@(posedge clk) disable iff (rst)
    hw_err |=> sts_q[ST_ERR]);
  a_r7_hw_irq_wins: assert property (@(posedge clk) disable iff (rst)
    hw_irq |=> sts_q[ST_IRQ]);
  // R5: status write never moves active flag
  a_r5_act_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && !wr_cmd) |=> $stable(sts_q[ST_ACT]));
endmodule

// File: rtl/bm_rdmux.sv
module bm_rdmux
  import bm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic [NCH*WIN_BYTES*8-1:0] img,
  input  logic [AW-1:0]              addr,
  input  logic [1:0]                 size,
  output logic [31:0]                data
);
  localparam int NBYTES = NCH * WIN_BYTES;

  always_comb begin
    data = '0;
    for (int i = 0; i < 4; i++) begin
      if ((i < (1 << size)) && ((int'(addr) + i) < NBYTES))
        data[8*i +: 8] = img[8*(int'(addr) + i) +: 8];
    end
  end
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 32,
  parameter int AW  = $clog2(NCH) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_en,
  input  logic              bm_en,
  input  logic              req,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  input  logic [NCH-1:0]    hw_irq,
  input  logic [NCH-1:0]    hw_err,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              acc_err,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    dma_abort,
  output logic [NCH*PW-1:0] dma_ptr
);
  localparam int CHW = AW - 3;

  logic [2:0]      off;
  logic [CHW-1:0]  ch;
  logic            wr_ok, rd_ok, do_wr, rd_req;
  logic [NCH*WIN_BYTES*8-1:0] img;
  logic [31:0]     rd_data;

  always_comb begin
    off    = addr[2:0];
    ch     = addr[AW-1:3];
    wr_ok  = ((off == 3'(OFF_CMD) || off == 3'(OFF_STS)) && size == SZ_BYTE) ||
             (off == 3'(OFF_PTR) && size == SZ_WORD);
    rd_ok  = (size != SZ_BAD) && ((int'(addr) % (1 << size)) == 0);
    do_wr  = req && we && io_en && bm_en && wr_ok;
    rd_req = req && !we;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]    cmd_q, sts_q;
    logic [PW-1:0] ptr_q;
    logic          sel;
    assign sel = (ch == CHW'(c));

    bm_chan #(.PW(PW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_cmd     (do_wr && sel && off == 3'(OFF_CMD)),
      .wr_sts     (do_wr && sel && off == 3'(OFF_STS)),
      .wr_ptr     (do_wr && sel && off == 3'(OFF_PTR)),
      .wdata      (PW'(wdata)),
      .hw_irq     (hw_irq[c]),
      .hw_err     (hw_err[c]),
      .cmd_q      (cmd_q),
      .sts_q      (sts_q),
      .ptr_q      (ptr_q),
      .start_o    (dma_start[c]),
      .abort_o    (dma_abort[c]),
      .start_ptr_o(dma_ptr[c*PW +: PW])
    );

    assign img[c*64 +: 64] = {ptr_q[31:0], 8'h00, sts_q, 8'h00, cmd_q};
  end

  bm_rdmux #(.NCH(NCH), .AW(AW)) u_rdmux (
    .img (img),
    .addr(addr),
    .size(size),
    .data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid  <= 1'b0;
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      rvalid  <= rd_req;
      rdata   <= (rd_req && io_en && rd_ok) ? rd_data : '0;
      acc_err <= req && io_en && (we ? (bm_en && !wr_ok) : !rd_ok);
    end
  end

  // R10: disabled I/O completes quietly
  a_r10_io_off: assert property (@(posedge clk) disable iff (rst)
    (req && !we && !io_en) |=> (rvalid && rdata == '0 && !acc_err));
  // R11: writes with bus mastering off start nothing
  a_r11_bm_off: assert property (@(posedge clk) disable iff (rst)
    (req && we && !bm_en) |=> (dma_start == '0 && dma_abort == '0 && !acc_err));
  // R12: bad size code flagged
  a_r12_bad_size: assert property (@(posedge clk) disable iff (rst)
    (req && io_en && size == SZ_BAD && (!we || bm_en)) |=> acc_err);
  // R9: no read, no completion
  a_r9_rvalid_only_read: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rvalid);
endmodule

// File: tb/sim_bm_dma_regs.sv
module sim_bm_dma_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, io_en = 1, bm_en = 1, req = 0, we = 0;
  logic [3:0]  addr = 0;
  logic [1:0]  size = 0;
  logic [31:0] wdata = 0;
  logic [1:0]  hw_irq = 0, hw_err = 0;
  logic        rvalid, acc_err;
  logic [31:0] rdata;
  logic [1:0]  dma_start, dma_abort;
  logic [63:0] dma_ptr;

  int checks = 0, failures = 0, cyc = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sts [2];
  logic [31:0] m_ptr [2];
  logic [31:0] m_sptr [2];

  bm_dma_regs u0 (.clk(clk), .rst(rst), .io_en(io_en), .bm_en(bm_en), .req(req),
    .we(we), .addr(addr), .size(size), .wdata(wdata), .hw_irq(hw_irq), .hw_err(hw_err),
    .rvalid(rvalid), .rdata(rdata), .acc_err(acc_err), .dma_start(dma_start),
    .dma_abort(dma_abort), .dma_ptr(dma_ptr));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog got=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] m_byte(input int c, input int o);
    case (o)
      0: return m_cmd[c];
      2: return m_sts[c];
      4: return m_ptr[c][7:0];
      5: return m_ptr[c][15:8];
      6: return m_ptr[c][23:16];
      7: return m_ptr[c][31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a, input logic [1:0] s);
    logic [31:0] d = 0;
    for (int i = 0; i < (1 << s) && i < 4; i++) begin
      int x = int'(a) + i;
      d[8*i +: 8] = m_byte(x / 8, x % 8);
    end
    return d;
  endfunction

  // one cycle: drive after negedge, compare after posedge against model
  task automatic step(input string tag, input bit rq, input bit w, input logic [3:0] a,
                      input logic [1:0] s, input logic [31:0] d, input logic [1:0] hi,
                      input logic [1:0] he, input bit io, input bit bm);
    bit rd_ok, wr_ok, dowr, rdq;
    int c, o;
    logic [1:0] e_st = 0, e_ab = 0;
    logic [31:0] e_rd;
    bit e_err;
    req = rq; we = w; addr = a; size = s; wdata = d; hw_irq = hi; hw_err = he;
    io_en = io; bm_en = bm;
    c = a[3]; o = a[2:0];
    rd_ok = (s != 3) && ((int'(a) % (1 << s)) == 0);
    wr_ok = ((o == 0 || o == 2) && s == 0) || (o == 4 && s == 2);
    rdq   = rq && !w;
    e_rd  = (rdq && io && rd_ok) ? m_read(a, s) : 32'h0;
    e_err = rq && io && (w ? (bm && !wr_ok) : !rd_ok);
    dowr  = rq && w && io && bm && wr_ok;
    if (dowr && o == 0) begin
      if (!m_cmd[c][0] && d[0]) begin
        e_st[c] = 1; m_sptr[c] = m_ptr[c]; m_sts[c][0] = 1;
      end else if (m_cmd[c][0] && !d[0]) begin
        e_ab[c] = 1; m_sts[c][0] = 0;
      end
      if (!m_cmd[c][0]) m_cmd[c][3] = d[3];
      m_cmd[c][0] = d[0];
    end
    if (dowr && o == 2) begin
      if (d[1]) m_sts[c][1] = 0;
      if (d[2]) m_sts[c][2] = 0;
      m_sts[c][6:5] = d[6:5];
    end
    if (dowr && o == 4) m_ptr[c] = {d[31:2], 2'b00};
    for (int k = 0; k < 2; k++) begin
      if (he[k]) m_sts[k][1] = 1;
      if (hi[k]) m_sts[k][2] = 1;
    end
    @(posedge clk); #1;
    chk({tag, " R9"}, "rvalid", 64'(rvalid), 64'(rdq));
    chk({tag, " R9"}, "rdata", 64'(rdata), 64'(e_rd));
    chk({tag, " R12"}, "acc_err", 64'(acc_err), 64'(e_err));
    chk({tag, " R3"}, "dma_start", 64'(dma_start), 64'(e_st));
    chk({tag, " R4"}, "dma_abort", 64'(dma_abort), 64'(e_ab));
    chk({tag, " R3"}, "dma_ptr", dma_ptr, {m_sptr[1], m_sptr[0]});
    @(negedge clk);
  endtask

  task automatic wr(input string t, input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    step(t, 1, 1, a, s, d, 2'b00, 2'b00, 1, 1);
  endtask
  task automatic rd(input string t, input logic [3:0] a, input logic [1:0] s);
    step(t, 1, 0, a, s, 0, 2'b00, 2'b00, 1, 1);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_cmd[k] = 0; m_sts[k] = 0; m_ptr[k] = 0; m_sptr[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset outputs", {rvalid, acc_err, dma_start, dma_abort, rdata}, 0);
    @(negedge clk); rst = 0;
    // R1 reset contents
    for (int a = 0; a < 16; a += 4) rd("R1", 4'(a), 2);

    // R8 pointer load with low bits dropped, R9 little-endian reads
    wr("R8", 4'd4, 2, 32'hA1B2C3D7);
    rd("R8", 4'd4, 2);
    rd("R9", 4'd6, 1);
    rd("R9", 4'd7, 0);
    // R13 other channel untouched
    rd("R13", 4'd12, 2);

    // R2 direction set while idle, R3 start
    wr("R2", 4'd0, 0, 32'h08);
    wr("R3", 4'd0, 0, 32'h09);
    rd("R3", 4'd0, 1);
    rd("R3", 4'd2, 0);
    // R2 direction locked while running
    wr("R2", 4'd0, 0, 32'h01);
    rd("R2", 4'd0, 0);
    // R4 no pulse while run stays 1
    wr("R4", 4'd0, 0, 32'h01);
    // R5 status write tries to clear active
    wr("R5", 4'd2, 0, 32'h00);
    rd("R5", 4'd2, 0);
    // R7 hardware sets; R6 clears and hw vs sw same cycle
    step("R7", 0, 0, 0, 0, 0, 2'b01, 2'b01, 1, 1);
    rd("R7", 4'd2, 0);
    step("R7", 1, 1, 4'd2, 0, 32'h06, 2'b01, 2'b00, 1, 1);
    rd("R7", 4'd2, 0);
    wr("R6", 4'd2, 0, 32'h00);
    rd("R6", 4'd2, 0);
    wr("R6", 4'd2, 0, 32'h66);
    rd("R6", 4'd2, 0);
    // R10 io disabled: write and read no effect
    step("R10", 1, 1, 4'd0, 0, 32'h00, 0, 0, 0, 1);
    step("R10", 1, 0, 4'd0, 0, 0, 0, 0, 0, 1);
    rd("R10", 4'd0, 0);
    // R11 bus master disabled: write ignored, read works
    step("R11", 1, 1, 4'd0, 0, 32'h00, 0, 0, 1, 0);
    step("R11", 1, 0, 4'd0, 0, 0, 0, 0, 1, 0);
    // R4 stop
    wr("R4", 4'd0, 0, 32'h00);
    rd("R4", 4'd2, 0);
    // R12 illegal accesses
    wr("R12", 4'd0, 2, 32'hFFFFFFFF);
    wr("R12", 4'd4, 0, 32'hFF);
    wr("R12", 4'd1, 0, 32'hFF);
    rd("R12", 4'd2, 2);
    rd("R12", 4'd0, 3);
    rd("R12", 4'd4, 2);
    // R13 second channel start
    wr("R13", 4'd12, 2, 32'h00001003);
    wr("R13", 4'd8, 0, 32'h01);
    rd("R13", 4'd0, 2);

    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [3:0] a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) begin
        int pick = $urandom_range(0, 2);
        a = {a[3], (pick == 0) ? 3'd0 : (pick == 1) ? 3'd2 : 3'd4};
        s = (pick == 2) ? 2'd2 : 2'd0;
      end
      step("random", $urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, s,
           $urandom, ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00,
           ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00,
           $urandom_range(0, 19) != 0, $urandom_range(0, 9) != 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule